// File: doc/BRIEF.md
# Oversampled Bi-phase Cell Recovery

This block turns a bi-phase line, sampled by a free-running clock that is not locked to the line, into a clean serial stream of cells. A cell lasts 180 ns and a sample period is 62.5 ns, so one cell spans about 2.88 samples and never a whole number of them. The block does not recover a clock. It passes the line through a two-stage synchroniser and counts how many samples in a row have the same polarity. When the polarity changes, it turns the length of the run that just ended into one, two or three cells of that polarity.

Downstream logic sees each recovered cell as a one-cycle `cellValid` strobe, with the cell's polarity on `cellBit`, in the sampling clock domain. A run whose length fits no legal class is mapped to the nearest class and flagged. A run that is too long for any legal signal also reports loss of lock. Bit decoding and preamble detection belong to later stages.

Top module: `biphase_cell_recover`

## Requirements
- R1: While reset is held and right after it, `cellValid`, `runError` and `lockLost` are 0, and an idle line produces no cells.
- R2: A run of 2 or 3 equal samples produces exactly one cell of the run's polarity, with no error flag.
- R3: A run of 5 or 6 equal samples produces exactly two cells of the run's polarity, with no error flag.
- R4: A run of 8 or 9 equal samples produces exactly three cells of the run's polarity, with no error flag.
- R5: When one run produces more than one cell and no earlier cells are waiting, its cells appear on consecutive clock cycles.
- R6: A run of 1, 4 or 7 samples produces one, two or three cells respectively, and raises `runError` for exactly one cycle. `lockLost` stays low.
- R7: A run of 10 or more samples produces three cells and raises `runError` and `lockLost` together for one cycle. The run counter saturates, so a line stuck for any length gives the same result.
- R8: The run in progress when reset is released is never turned into cells, whatever its level or length. Every later run is turned into cells, in line order and with its own polarity (`cellBit` 1 for high, 0 for low).
- R9: When no earlier cells are waiting, the first cell of a run appears on `cellValid` four clock cycles after the line leaves that run's level.
- R10: If a run ends while the cells of the previous run are still being sent, its cells follow the previous run's cells with nothing lost and the order kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Raw bi-phase line, asynchronous to clk |
| cellValid | output | 1 | One-cycle strobe per recovered cell |
| cellBit | output | 1 | Polarity of the recovered cell |
| runError | output | 1 | One-cycle flag for a run length outside the legal classes |
| lockLost | output | 1 | One-cycle flag for a run of 10 or more samples |

## Verification
The bench runs every pair of run lengths from 1 to 12 after both idle polarities. So every boundary between classes (3 and 4, 6 and 7, 9 and 10) is crossed, and a design with a threshold off by one would produce a wrong cell count or a wrong error flag at exactly one length. Long runs followed by short ones make a new run end while cells are still being sent. A design without the waiting slot would drop or reorder cells there. A dedicated idle-high case catches a design that classifies the run in progress at reset, which would emit spurious cells with a loss-of-lock flag. A forty-sample stuck line catches a counter that wraps instead of saturating, because a wrapped count would land in a short class.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  // Event strobes the run counter hands to the classifier
  typedef struct packed {
    logic runEnd;  // polarity changed this cycle; the previous run is complete
    logic runLvl;  // polarity of the run that just ended
  } runEvt_t;
endpackage

// File: rtl/bpc_runcount.sv
module bpc_runcount
  import bpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  output runEvt_t          evt,
  output logic [CNT_W-1:0] runLen
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic syncA, syncB, prevLvl;
  logic [1:0] fillCnt;
  logic [CNT_W-1:0] runCount;
  logic edgeSeen;

  // compare only once syncA, syncB and prevLvl all hold real line samples
  assign edgeSeen = (fillCnt == 2'd3) && (syncB != prevLvl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      prevLvl  <= 1'b0;
      fillCnt  <= 2'd0;
      runCount <= '0;
    end else begin
      syncA   <= lineIn;
      syncB   <= syncA;
      prevLvl <= syncB;
      if (fillCnt != 2'd3) fillCnt <= fillCnt + 2'd1;
      if (edgeSeen) runCount <= CNT_ONE;
      else if (runCount != CNT_MAX) runCount <= runCount + CNT_ONE;
    end
  end

  assign evt.runEnd = edgeSeen;
  assign evt.runLvl = prevLvl;
  assign runLen     = runCount;

  // saturated counter holds its value while the line stays put (R7)
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runCount == CNT_MAX && !edgeSeen) |=> (runCount == CNT_MAX));

  // a completed run always has at least one sample (R8)
  p_run_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    evt.runEnd |-> (runLen != '0));
endmodule

// File: rtl/bpc_classify.sv
module bpc_classify
  import bpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  runEvt_t          evt,
  input  logic [CNT_W-1:0] runLen,
  output logic             cellValid,
  output logic             cellBit,
  output logic             runError,
  output logic             lockLost
);
  // run-length class limits for roughly 2.88 samples per cell
  localparam int LIM_ONE = 3;
  localparam int LIM_TWO = 6;
  localparam int LIM_TRI = 9;

  int unsigned lenI;
  logic [1:0] cellsNeeded;
  logic lenBad, lenLock;
  logic primed, take;

  logic [1:0] activeRem, activeRemN;
  logic activeLvl, activeLvlN;
  logic holdValid, holdValidN;
  logic [1:0] holdCnt, holdCntN;
  logic holdLvl, holdLvlN;
  logic slotFree;

  assign lenI = int'(runLen);

  always_comb begin
    lenBad  = 1'b0;
    lenLock = 1'b0;
    if (lenI <= LIM_ONE) begin
      cellsNeeded = 2'd1;
      lenBad      = (lenI <= 1);
    end else if (lenI <= LIM_TWO) begin
      cellsNeeded = 2'd2;
      lenBad      = (lenI == LIM_ONE + 1);
    end else if (lenI <= LIM_TRI) begin
      cellsNeeded = 2'd3;
      lenBad      = (lenI == LIM_TWO + 1);
    end else begin
      cellsNeeded = 2'd3;
      lenBad      = 1'b1;
      lenLock     = 1'b1;
    end
  end

  assign take = evt.runEnd && primed;

  always_comb begin
    activeRemN = (activeRem != 2'd0) ? activeRem - 2'd1 : 2'd0;
    activeLvlN = activeLvl;
    holdValidN = holdValid;
    holdCntN   = holdCnt;
    holdLvlN   = holdLvl;
    slotFree   = (activeRemN == 2'd0);
    if (slotFree && holdValid) begin
      activeRemN = holdCnt;
      activeLvlN = holdLvl;
      holdValidN = 1'b0;
    end
    if (take) begin
      if (slotFree && !holdValid) begin
        activeRemN = cellsNeeded;
        activeLvlN = evt.runLvl;
      end else begin
        holdValidN = 1'b1;
        holdCntN   = cellsNeeded;
        holdLvlN   = evt.runLvl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed    <= 1'b0;
      activeRem <= 2'd0;
      activeLvl <= 1'b0;
      holdValid <= 1'b0;
      holdCnt   <= 2'd0;
      holdLvl   <= 1'b0;
      cellValid <= 1'b0;
      cellBit   <= 1'b0;
      runError  <= 1'b0;
      lockLost  <= 1'b0;
    end else begin
      if (evt.runEnd) primed <= 1'b1;
      activeRem <= activeRemN;
      activeLvl <= activeLvlN;
      holdValid <= holdValidN;
      holdCnt   <= holdCntN;
      holdLvl   <= holdLvlN;
      cellValid <= (activeRem != 2'd0);
      cellBit   <= (activeRem != 2'd0) ? activeLvl : 1'b0;
      runError  <= take && lenBad;
      lockLost  <= take && lenLock;
    end
  end

  // loss of lock is always reported as an error too (R7)
  p_lock_has_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockLost |-> runError);

  // a waiting run only exists behind one that is still sending (R10)
  p_hold_behind_r10: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> (activeRem != 2'd0));

  // a run that leaves cells still owed keeps sending on the next cycle (R5)
  p_burst_r5: assert property (@(posedge clk) disable iff (!rstN)
    (activeRem > 2'd1) |=> cellValid);

  // the run in progress at reset release yields no event (R8)
  p_first_run_r8: assert property (@(posedge clk) disable iff (!rstN)
    !primed |=> (activeRem == 2'd0 && !holdValid));
endmodule

// File: rtl/biphase_cell_recover.sv
module biphase_cell_recover
  import bpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic cellValid,
  output logic cellBit,
  output logic runError,
  output logic lockLost
);
  runEvt_t evt;
  logic [CNT_W-1:0] runLen;

  bpc_runcount #(.CNT_W(CNT_W)) uCount (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .evt    (evt),
    .runLen (runLen)
  );

  bpc_classify #(.CNT_W(CNT_W)) uClass (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .runLen    (runLen),
    .cellValid (cellValid),
    .cellBit   (cellBit),
    .runError  (runError),
    .lockLost  (lockLost)
  );

  // no error flags while cells cannot yet have been classified (R1)
  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!cellValid && !runError && !lockLost));
endmodule

// File: tb/tb_biphase_cell_recover.sv
module tb_biphase_cell_recover;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0;
  logic cellValid, cellBit, runError, lockLost;

  always #10 clk = ~clk;

  biphase_cell_recover dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .cellValid(cellValid), .cellBit(cellBit),
    .runError(runError), .lockLost(lockLost)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic cellArr [0:31];
  int   cellCyc [0:31];
  int   cellN = 0;
  int   errN = 0;
  int   lockN = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cellValid && cellN < 32) begin
      cellArr[cellN] = cellBit;
      cellCyc[cellN] = cyc;
      cellN = cellN + 1;
    end
    if (runError) errN = errN + 1;
    if (lockLost) lockN = lockN + 1;
  end

  function automatic int clsCells(int n);
    if (n <= 3) return 1;
    if (n <= 6) return 2;
    return 3;
  endfunction

  function automatic int clsErr(int n);
    return (n == 1 || n == 4 || n == 7 || n >= 10) ? 1 : 0;
  endfunction

  function automatic string reqOf(int n);
    if (n == 2 || n == 3) return "R2";
    if (n == 5 || n == 6) return "R3";
    if (n == 8 || n == 9) return "R4";
    if (n == 1 || n == 4 || n == 7) return "R6";
    return "R7";
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic startUp(logic idleLvl, int idleLen);
    rstN = 1'b0;
    lineIn = idleLvl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cellN = 0; errN = 0; lockN = 0;
    repeat (idleLen) @(negedge clk);
  endtask

  task automatic driveRun(logic lvl, int n);
    lineIn = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic runPair(logic s, int a, int b);
    logic expArr [0:31];
    int expN = 0;
    bit seqOk;
    startUp(s, 6);
    driveRun(~s, a);
    driveRun(s, b);
    driveRun(~s, 3);
    lineIn = s;
    repeat (14) @(negedge clk);
    for (int i = 0; i < clsCells(a); i++) begin expArr[expN] = ~s; expN++; end
    for (int i = 0; i < clsCells(b); i++) begin expArr[expN] = s; expN++; end
    expArr[expN] = ~s; expN++;
    check(cellN == expN, reqOf(a), cellN, expN, $sformatf("cell count a=%0d b=%0d", a, b));
    seqOk = (cellN == expN);
    for (int i = 0; i < expN; i++) if (seqOk && cellArr[i] !== expArr[i]) seqOk = 1'b0;
    check(seqOk, "R8", cellN, expN, $sformatf("cell order/polarity a=%0d b=%0d", a, b));
    check(errN == clsErr(a) + clsErr(b), reqOf(b), errN, clsErr(a) + clsErr(b),
          $sformatf("runError pulses a=%0d b=%0d", a, b));
    check(lockN == int'(a >= 10) + int'(b >= 10), "R7", lockN,
          int'(a >= 10) + int'(b >= 10), $sformatf("lockLost pulses a=%0d b=%0d", a, b));
    if (clsCells(a) > 1 && cellN >= clsCells(a)) begin
      bit back = 1'b1;
      for (int i = 1; i < clsCells(a); i++) if (cellCyc[i] != cellCyc[i-1] + 1) back = 1'b0;
      check(back, "R5", cellCyc[clsCells(a)-1] - cellCyc[0], clsCells(a) - 1,
            $sformatf("consecutive cells a=%0d", a));
    end
  endtask

  initial begin
    int tStart;
    // R1: reset state and idle line
    rstN = 1'b0;
    lineIn = 1'b0;
    repeat (3) @(negedge clk);
    check(!cellValid && !runError && !lockLost, "R1", {cellValid, runError, lockLost}, 0, "outputs during reset");
    startUp(1'b0, 10);
    check(cellN == 0 && errN == 0, "R1", cellN + errN, 0, "idle line after reset");

    // R8: idle-high at reset is a partial run and is never classified
    startUp(1'b1, 30);
    driveRun(1'b0, 3);
    lineIn = 1'b1;
    repeat (12) @(negedge clk);
    check(cellN == 1 && lockN == 0 && errN == 0, "R8", cellN, 1, "partial run at reset ignored");

    // R9: latency from line change to first cell
    startUp(1'b0, 6);
    driveRun(1'b1, 3);
    tStart = cyc;
    lineIn = 1'b0;
    repeat (10) @(negedge clk);
    check(cellN >= 1 && cellCyc[0] - tStart == 4, "R9", cellN >= 1 ? cellCyc[0] - tStart : -1, 4, "first cell latency");

    // R10: run ends while the previous run's three cells are still going out
    runPair(1'b0, 9, 2);
    check(cellN == 5 && cellArr[3] == 1'b0 && cellCyc[3] == cellCyc[2] + 1, "R10", cellN, 5, "queued run follows burst");

    // R7: stuck line well past counter saturation
    startUp(1'b0, 6);
    driveRun(1'b1, 40);
    lineIn = 1'b0;
    repeat (12) @(negedge clk);
    check(cellN == 3 && errN == 1 && lockN == 1, "R7", cellN * 100 + errN * 10 + lockN, 311, "stuck line (cells,err,lock)");

    // R2 R3 R4 R6 R7 R8: all pairs of run lengths, both idle polarities
    for (int s = 0; s < 2; s++)
      for (int a = 1; a <= 12; a++)
        for (int b = 1; b <= 12; b++)
          runPair(logic'(s), a, b);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule